// File: doc/BRIEF.md
# Privileged Processor Status Register

This block is the control/status word of a small CPU control coprocessor. One 32-bit register holds the privilege selection, the exception and error levels, the global interrupt enable, an eight-line interrupt mask, four coprocessor enable bits, a user byte-order flip bit and a diagnostic field. Software reads the whole word through a plain combinational read bus. It writes the word through a one-cycle write strobe that comes with a 32-bit data word. Separate strobes from the exception sequencer set and clear the exception-level bit.

The register decodes its contents into the signals that the rest of the core uses. These are the effective privilege mode, a masked interrupt request built from eight external pending lines, one usable flag per coprocessor, and the effective data byte order. All of these are control signals with no flow control, so the block has no valid/ready interface. A write takes effect on the next rising clock edge, and the decoded outputs follow the stored word combinationally.

Top module: `psr_core`

## Requirements
- R1: While the synchronous active-low reset is low, the register loads the error-level bit (bit 2) as 1 and every other stored bit as 0. Read data right after reset is therefore 0x00000004, with bit 21 showing the hardware flag input.
- R2: With the write strobe high, every bit except bit 21 takes the write data at the next rising edge. With the strobe low, the stored word does not change. The bit layout is: bits 31:28 coprocessor enables (bit 28 is coprocessor 0), bit 25 user byte-order flip, bits 24:16 diagnostic, bits 15:8 interrupt mask, bits 4:3 privilege field, bit 2 error level, bit 1 exception level, bit 0 interrupt enable.
- R3: Bit 21 of the read data always equals the hardware flag input, and software writes to it have no effect.
- R4: The effective mode output is 00 (kernel) whenever bit 1 or bit 2 is 1, or when the privilege field is 00. Otherwise it is 01 (supervisor) for field 01 and 10 (user) for field 10 or 11.
- R5: The interrupt request is 1 exactly when bit 0 is 1, bits 1 and 2 are both 0, and for at least one line n both mask bit 8+n and pending line n are 1.
- R6: Coprocessor usable flag n equals enable bit 28+n. Flag 0 is also forced to 1 whenever the effective mode is kernel.
- R7: The base byte order is taken from the configuration input during reset and is kept until the next reset. The effective byte order output (1 = big) equals that base, inverted only when the effective mode is user and bit 25 is 1.
- R8: An exception-entry strobe sets bit 1 and an exception-return strobe clears it at the next edge. Entry wins over return. Both win over a software write to bit 1 in the same cycle, while the other written bits still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| big_end_cfg | input | 1 | Base byte order sampled during reset (1 = big) |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Software write data |
| rd_data | output | 32 | Current register contents |
| exc_enter | input | 1 | Exception-entry strobe, sets exception level |
| exc_return | input | 1 | Exception-return strobe, clears exception level |
| hw_flag | input | 1 | Hardware-owned diagnostic flag shown at bit 21 |
| irq_pending | input | 8 | External interrupt pending lines |
| irq_req | output | 1 | Masked interrupt request |
| eff_mode | output | 2 | Effective privilege mode (00 kernel, 01 supervisor, 10 user) |
| cop_usable | output | 4 | Per-coprocessor usable flags |
| eff_big_end | output | 1 | Effective data byte order (1 = big) |

## Verification
The bound checker watches several relations on every cycle. It checks that a request never appears while interrupts are disabled or an exception level is set, and that coprocessor 0 is usable in kernel mode. It checks that bit 21 tracks the hardware flag, that exception strobes move bit 1 with the right priority, that an unstrobed cycle leaves the word unchanged, and that kernel and supervisor byte order stays fixed. Only the bench scenarios can show the exact decode values: the mode table for each privilege field, the user byte-order flip against both reset-time base settings, the exact reset word, and the survival of other written bits when a strobe overrides bit 1.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int DATA_W  = 32;
  localparam int NUM_IRQ = 8;
  localparam int NUM_COP = 4;

  // bit positions software relies on
  localparam int POS_IE      = 0;
  localparam int POS_EXC     = 1;
  localparam int POS_ERR     = 2;
  localparam int POS_PRIV_LO = 3;
  localparam int POS_MASK_LO = 8;
  localparam int POS_HWFLAG  = 21;
  localparam int POS_FLIP    = 25;
  localparam int POS_COP_LO  = 28;

  typedef enum logic [1:0] {
    MODE_KERN = 2'b00,
    MODE_SUPV = 2'b01,
    MODE_USER = 2'b10
  } priv_e;

  localparam logic [DATA_W-1:0] RESET_WORD = DATA_W'(1) << POS_ERR;
  localparam logic [DATA_W-1:0] SW_MASK    = ~(DATA_W'(1) << POS_HWFLAG);
endpackage

// File: rtl/psr_regfile.sv
module psr_regfile
  import psr_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         base_cfg,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         exc_enter,
  input  logic         exc_return,
  input  logic         hw_flag,
  output logic [W-1:0] state_q,
  output logic [W-1:0] rd_data,
  output logic         base_big
);
  logic [W-1:0] state_d;
  logic         base_q;

  always_comb begin
    state_d = state_q;
    if (wr_en) state_d = (wr_data & SW_MASK) | (state_q & ~SW_MASK);
    if (exc_enter)       state_d[POS_EXC] = 1'b1;
    else if (exc_return) state_d[POS_EXC] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= RESET_WORD;
      base_q  <= base_cfg;
    end else begin
      state_q <= state_d;
    end
  end

  always_comb begin
    rd_data             = state_q;
    rd_data[POS_HWFLAG] = hw_flag;
  end

  assign base_big = base_q;
endmodule

// File: rtl/psr_mode_dec.sv
module psr_mode_dec
  import psr_pkg::*;
#(
  parameter int W    = DATA_W,
  parameter int NCOP = NUM_COP
) (
  input  logic [W-1:0]    state,
  input  logic            base_big,
  output priv_e           mode,
  output logic [NCOP-1:0] cop_ok,
  output logic            big_end
);
  logic [1:0] priv_fld;
  logic       kern;

  assign priv_fld = state[POS_PRIV_LO +: 2];

  always_comb begin
    if (state[POS_EXC] || state[POS_ERR]) mode = MODE_KERN;
    else begin
      unique case (priv_fld)
        2'b00:   mode = MODE_KERN;
        2'b01:   mode = MODE_SUPV;
        default: mode = MODE_USER;
      endcase
    end
  end

  assign kern = (mode == MODE_KERN);

  for (genvar g = 0; g < NCOP; g++) begin : g_cop
    if (g == 0) begin : g_zero
      assign cop_ok[g] = state[POS_COP_LO + g] | kern;
    end else begin : g_other
      assign cop_ok[g] = state[POS_COP_LO + g];
    end
  end

  assign big_end = base_big ^ ((mode == MODE_USER) & state[POS_FLIP]);
endmodule

// File: rtl/psr_irq_ctl.sv
module psr_irq_ctl #(
  parameter int NIRQ = psr_pkg::NUM_IRQ
) (
  input  logic [NIRQ-1:0] mask,
  input  logic [NIRQ-1:0] pending,
  input  logic            int_en,
  input  logic            exc_lvl,
  input  logic            err_lvl,
  output logic            req
);
  logic [NIRQ-1:0] hit;

  for (genvar n = 0; n < NIRQ; n++) begin : g_line
    assign hit[n] = mask[n] & pending[n];
  end

  assign req = int_en & ~exc_lvl & ~err_lvl & (|hit);
endmodule

// File: rtl/psr_core.sv
module psr_core
  import psr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 big_end_cfg,
  input  logic                 wr_en,
  input  logic [DATA_W-1:0]    wr_data,
  output logic [DATA_W-1:0]    rd_data,
  input  logic                 exc_enter,
  input  logic                 exc_return,
  input  logic                 hw_flag,
  input  logic [NUM_IRQ-1:0]   irq_pending,
  output logic                 irq_req,
  output logic [1:0]           eff_mode,
  output logic [NUM_COP-1:0]   cop_usable,
  output logic                 eff_big_end
);
  logic [DATA_W-1:0] state_q;
  logic              base_big;
  priv_e             mode;

  psr_regfile #(.W(DATA_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .base_cfg(big_end_cfg),
    .wr_en(wr_en), .wr_data(wr_data),
    .exc_enter(exc_enter), .exc_return(exc_return),
    .hw_flag(hw_flag), .state_q(state_q), .rd_data(rd_data),
    .base_big(base_big)
  );

  psr_mode_dec #(.W(DATA_W), .NCOP(NUM_COP)) dec_i (
    .state(state_q), .base_big(base_big), .mode(mode),
    .cop_ok(cop_usable), .big_end(eff_big_end)
  );

  psr_irq_ctl #(.NIRQ(NUM_IRQ)) irq_i (
    .mask(state_q[POS_MASK_LO +: NUM_IRQ]), .pending(irq_pending),
    .int_en(state_q[POS_IE]), .exc_lvl(state_q[POS_EXC]),
    .err_lvl(state_q[POS_ERR]), .req(irq_req)
  );

  assign eff_mode = mode;
endmodule

// File: rtl/psr_core_chk.sv
module psr_core_chk
  import psr_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [DATA_W-1:0]  wr_data,
  input logic [DATA_W-1:0]  rd_data,
  input logic               exc_enter,
  input logic               exc_return,
  input logic               hw_flag,
  input logic [NUM_IRQ-1:0] irq_pending,
  input logic               irq_req,
  input logic [1:0]         eff_mode,
  input logic [NUM_COP-1:0] cop_usable,
  input logic               eff_big_end
);
  // R5
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (rd_data[POS_IE] && !rd_data[POS_EXC] && !rd_data[POS_ERR]
                 && |(rd_data[POS_MASK_LO +: NUM_IRQ] & irq_pending)));

  // R6
  cop0_kern_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_mode == 2'b00) |-> cop_usable[0]);

  // R3
  hw_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[POS_HWFLAG] == hw_flag);

  // R8
  exc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_enter |=> rd_data[POS_EXC]);

  // R8
  exc_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_return && !exc_enter) |=> !rd_data[POS_EXC]);

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !exc_enter && !exc_return) |=>
      ((rd_data & SW_MASK) == ($past(rd_data) & SW_MASK)));

  // R1
  reset_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> rd_data[POS_ERR]);

  // R7
  base_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_mode != 2'b10 && $past(eff_mode) != 2'b10 && $past(rst_n))
      |-> $stable(eff_big_end));
endmodule

bind psr_core psr_core_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .exc_enter(exc_enter), .exc_return(exc_return),
  .hw_flag(hw_flag), .irq_pending(irq_pending), .irq_req(irq_req),
  .eff_mode(eff_mode), .cop_usable(cop_usable), .eff_big_end(eff_big_end)
);

// File: tb/psr_core_tb_top.sv
module psr_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        big_end_cfg = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        exc_enter = 1'b0;
  logic        exc_return = 1'b0;
  logic        hw_flag = 1'b0;
  logic [7:0]  irq_pending = '0;
  logic        irq_req;
  logic [1:0]  eff_mode;
  logic [3:0]  cop_usable;
  logic        eff_big_end;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  psr_core dut_i (
    .clk(clk), .rst_n(rst_n), .big_end_cfg(big_end_cfg),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .exc_enter(exc_enter), .exc_return(exc_return), .hw_flag(hw_flag),
    .irq_pending(irq_pending), .irq_req(irq_req), .eff_mode(eff_mode),
    .cop_usable(cop_usable), .eff_big_end(eff_big_end)
  );

  typedef struct packed {
    logic [31:0] wr;
    logic [7:0]  pend;
    logic        irq;
    logic [1:0]  mode;
    logic [3:0]  cop;
    logic        big;
  } vec_t;

  // base byte order little (cfg 0) for the table
  localparam vec_t VECS [0:14] = '{
    '{32'h0000_0000, 8'h00, 1'b0, 2'b00, 4'b0001, 1'b0},
    '{32'h0000_0101, 8'h01, 1'b1, 2'b00, 4'b0001, 1'b0},
    '{32'h0000_0101, 8'h02, 1'b0, 2'b00, 4'b0001, 1'b0},
    '{32'h0000_0100, 8'h01, 1'b0, 2'b00, 4'b0001, 1'b0},
    '{32'h0000_0103, 8'h01, 1'b0, 2'b00, 4'b0001, 1'b0},
    '{32'h0000_0105, 8'h01, 1'b0, 2'b00, 4'b0001, 1'b0},
    '{32'h0200_0008, 8'h00, 1'b0, 2'b01, 4'b0000, 1'b0},
    '{32'h0200_0010, 8'h00, 1'b0, 2'b10, 4'b0000, 1'b1},
    '{32'h0200_0018, 8'h00, 1'b0, 2'b10, 4'b0000, 1'b1},
    '{32'h0000_0010, 8'h00, 1'b0, 2'b10, 4'b0000, 1'b0},
    '{32'hA000_0010, 8'h00, 1'b0, 2'b10, 4'b1010, 1'b0},
    '{32'h5000_0000, 8'h00, 1'b0, 2'b00, 4'b0101, 1'b0},
    '{32'h1000_0010, 8'h00, 1'b0, 2'b10, 4'b0001, 1'b0},
    '{32'hFF00_FF11, 8'h80, 1'b1, 2'b10, 4'b1111, 1'b1},
    '{32'h0200_0012, 8'h00, 1'b0, 2'b00, 4'b0001, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic cfg);
    @(negedge clk);
    rst_n = 1'b0;
    big_end_cfg = cfg;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    big_end_cfg = ~cfg;  // must no longer matter
  endtask

  task automatic sw_write(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset(1'b0);
    check("R1 reset word", rd_data, 32'h0000_0004);
    check("R4 reset mode", {30'd0, eff_mode}, 32'd0);
    check("R6 reset cop", {28'd0, cop_usable}, 32'h1);
    check("R5 reset irq", {31'd0, irq_req}, 32'd0);
    check("R7 reset byte order", {31'd0, eff_big_end}, 32'd0);

    // table walk: R2 R4 R5 R6 R7
    for (int i = 0; i < 15; i++) begin
      sw_write(VECS[i].wr);
      irq_pending = VECS[i].pend;
      #1;
      check("R2 readback", rd_data, VECS[i].wr);
      check("R5 irq", {31'd0, irq_req}, {31'd0, VECS[i].irq});
      check("R4 mode", {30'd0, eff_mode}, {30'd0, VECS[i].mode});
      check("R6 cop", {28'd0, cop_usable}, {28'd0, VECS[i].cop});
      check("R7 byte order", {31'd0, eff_big_end}, {31'd0, VECS[i].big});
    end
    irq_pending = '0;

    // R2 strobe low leaves the word alone
    @(negedge clk);
    wr_data = 32'hFFFF_FFFF;
    repeat (2) @(negedge clk);
    check("R2 no write", rd_data, 32'h0200_0012);

    // R3 hardware flag bit
    sw_write(32'h0020_0000);
    check("R3 write ignored", rd_data, 32'h0000_0000);
    hw_flag = 1'b1;
    #1;
    check("R3 follows input", rd_data, 32'h0020_0000);
    sw_write(32'h0000_0000);
    check("R3 write zero ignored", rd_data, 32'h0020_0000);
    hw_flag = 1'b0;

    // R8 exception strobes
    sw_write(32'h0000_0111);
    irq_pending = 8'h01;
    #1;
    check("R5 user irq", {31'd0, irq_req}, 32'd1);
    @(negedge clk);
    exc_enter = 1'b1;
    @(negedge clk);
    exc_enter = 1'b0;
    check("R8 entry sets", rd_data, 32'h0000_0113);
    check("R8 entry kernel", {30'd0, eff_mode}, 32'd0);
    check("R5 masked by exc", {31'd0, irq_req}, 32'd0);
    @(negedge clk);
    exc_return = 1'b1;
    @(negedge clk);
    exc_return = 1'b0;
    check("R8 return clears", rd_data, 32'h0000_0111);
    check("R4 back to user", {30'd0, eff_mode}, 32'd2);
    // entry beats a write clearing bit 1; other bits land
    @(negedge clk);
    exc_enter = 1'b1;
    wr_en = 1'b1;
    wr_data = 32'h0000_0208;
    @(negedge clk);
    exc_enter = 1'b0;
    wr_en = 1'b0;
    check("R8 entry over write", rd_data, 32'h0000_020A);
    // entry beats return
    @(negedge clk);
    exc_enter = 1'b1;
    exc_return = 1'b1;
    @(negedge clk);
    exc_enter = 1'b0;
    exc_return = 1'b0;
    check("R8 entry over return", rd_data, 32'h0000_020A);
    // return beats a write setting bit 1
    @(negedge clk);
    exc_return = 1'b1;
    wr_en = 1'b1;
    wr_data = 32'h0000_0403;
    @(negedge clk);
    exc_return = 1'b0;
    wr_en = 1'b0;
    check("R8 return over write", rd_data, 32'h0000_0401);
    irq_pending = '0;

    // R7 big-endian base
    do_reset(1'b1);
    check("R1 reset word again", rd_data, 32'h0000_0004);
    check("R7 kernel big", {31'd0, eff_big_end}, 32'd1);
    sw_write(32'h0200_0010);
    check("R7 user flipped", {31'd0, eff_big_end}, 32'd0);
    sw_write(32'h0000_0010);
    check("R7 user base", {31'd0, eff_big_end}, 32'd1);
    sw_write(32'h0200_0008);
    check("R7 supervisor base", {31'd0, eff_big_end}, 32'd1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule